// File: doc/BRIEF.md
# Timer Interrupt Router

This block sits between a bank of timer channels and the interrupt fabric of a chip. Each channel sends a one-cycle fire pulse when its comparison matches. The router turns that pulse into activity on one of a set of interrupt lines, or into a 32-bit message write. Channel configuration reaches the block as plain input ports from a register file elsewhere: the enable, the trigger type, the line select, the message enable, and the 64-bit message route.

A level-type fire sets the channel's bit in a status vector and holds its line high until software clears the bit. Software clears a bit by writing a one to it. An edge-type fire pulses its line for one cycle and leaves its status bit clear. When a channel has message routing on, it touches no line. Instead it raises a valid/ready request that carries the address and data taken from its route value.

A legacy replacement mode lets channel 0 take line 0 and channel 1 take line 8, whatever their line selects say. In this mode the block also turns off the old system timer through an enable output. Outside this mode, two legacy inputs (a system-timer tick and a real-time-clock interrupt) pass straight through to lines 0 and 8.

Top module: `timer_irq_router`

## Requirements
- R1: After reset the status vector is all zero, every interrupt line is low, `msg_valid` is low and `tmr_legacy_en` is high.
- R2: A fire on an enabled level-type channel (`ch_level`=1, message routing off) sets that channel's status bit and drives its selected line (`ch_route` field c, line index = field value) high from the next cycle on. The line stays high while the bit is set.
- R3: A fire on an enabled edge-type channel (`ch_level`=0, message routing off) clears its status bit and drives its selected line high for exactly one cycle, starting the next cycle.
- R4: A cycle with `sts_wr` high clears every status bit that is one in both `sts_wdata` and the current status vector, and lowers the lines those bits held. Other bits are kept. A fire in the same cycle takes priority over the clear for its own channel.
- R5: While `glb_en` is low or a channel's `ch_enable` bit is low, that channel's status bit is cleared, its line is released, and its fires are ignored.
- R6: While `legacy_mode` is high, channel 0 uses line 0 and channel 1 uses line 8, whatever their route fields hold. Channels 2 and above keep their route fields.
- R7: While `legacy_mode` is low, `tmr_legacy_in` drives line 0 and `rtc_legacy_in` drives line 8 one cycle later. While it is high, neither input reaches a line. `tmr_legacy_en` follows the inverse of `legacy_mode` one cycle later. When legacy mode is left, line 8 therefore takes the current clock-input level again.
- R8: A fire on an enabled channel with `ch_msg_en` set touches no line and no status bit. Two cycles later it raises `msg_valid` with `msg_addr` equal to bits 63:32 of the channel's 64-bit route value and `msg_data` equal to bits 31:0. The request holds, with address and data stable, until `msg_ready` is seen high.
- R9: Message fires that are pending together are issued one request per accepted cycle, lowest channel index first, and each is issued exactly once.
- R10: Turning on `ch_msg_en` for a channel clears its status bit and releases its line on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_en | input | 1 | Global enable of all channels |
| legacy_mode | input | 1 | Legacy replacement routing on |
| ch_fire | input | NUM_CH | One-cycle fire pulse per channel |
| ch_enable | input | NUM_CH | Per-channel enable |
| ch_level | input | NUM_CH | 1 = level-type, 0 = edge-type |
| ch_msg_en | input | NUM_CH | Per-channel message routing on |
| ch_route | input | NUM_CH*ROUTE_W | Packed line select per channel |
| ch_msg_route | input | NUM_CH*64 | Packed message route, address high half, data low half |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | NUM_CH | Write-one-to-clear mask |
| sts | output | NUM_CH | Status vector |
| tmr_legacy_in | input | 1 | Legacy system-timer interrupt input |
| rtc_legacy_in | input | 1 | Legacy real-time-clock interrupt input |
| irq_line | output | NUM_LINES | Interrupt lines |
| tmr_legacy_en | output | 1 | Enable for the legacy system timer |
| msg_valid | output | 1 | Message write request valid |
| msg_ready | input | 1 | Message write accepted |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
Status bits, interrupt lines and the legacy enable all pass through one register. Each is due one cycle after the edge that samples its stimulus. A message request passes through a pending register and then an output register, so `msg_valid` is due two cycles after the fire. The bench drives inputs on falling edges and samples on the falling edge after the due rising edge. This lets it tell a one-cycle edge pulse from a held level. The line sweep covers every channel, every line select and both trigger types of a four-channel, sixteen-line configuration. In the queued-message case, the bench checks each cycle of the issue order.

// File: rtl/tir_pkg.sv
package tir_pkg;
    localparam int LINE_TMR = 0;
    localparam int LINE_RTC = 8;
    localparam int MSG_ROUTE_W = 64;
endpackage

// File: rtl/tir_route_sel.sv
module tir_route_sel #(
    parameter int NUM_CH  = 8,
    parameter int ROUTE_W = 5
) (
    input  logic                      legacy_mode,
    input  logic [NUM_CH*ROUTE_W-1:0] route_cfg,
    output logic [NUM_CH*ROUTE_W-1:0] route_eff
);
    import tir_pkg::*;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        if (c == 0) begin : g_tmr
            assign route_eff[c*ROUTE_W +: ROUTE_W] =
                legacy_mode ? ROUTE_W'(LINE_TMR) : route_cfg[c*ROUTE_W +: ROUTE_W];
        end else if (c == 1) begin : g_rtc
            assign route_eff[c*ROUTE_W +: ROUTE_W] =
                legacy_mode ? ROUTE_W'(LINE_RTC) : route_cfg[c*ROUTE_W +: ROUTE_W];
        end else begin : g_plain
            assign route_eff[c*ROUTE_W +: ROUTE_W] = route_cfg[c*ROUTE_W +: ROUTE_W];
        end
    end
endmodule

// File: rtl/tir_line_map.sv
module tir_line_map #(
    parameter int NUM_CH    = 8,
    parameter int NUM_LINES = 24,
    parameter int ROUTE_W   = 5
) (
    input  logic [NUM_CH-1:0]         active,
    input  logic [NUM_CH*ROUTE_W-1:0] route_eff,
    input  logic                      legacy_mode,
    input  logic                      tmr_in,
    input  logic                      rtc_in,
    output logic [NUM_LINES-1:0]      lines
);
    import tir_pkg::*;

    logic [NUM_LINES-1:0][NUM_CH-1:0] hit;

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            assign hit[l][c] = active[c] &&
                (route_eff[c*ROUTE_W +: ROUTE_W] == ROUTE_W'(l));
        end
        if (l == LINE_TMR) begin : g_tmr
            assign lines[l] = (|hit[l]) | (!legacy_mode && tmr_in);
        end else if (l == LINE_RTC) begin : g_rtc
            assign lines[l] = (|hit[l]) | (!legacy_mode && rtc_in);
        end else begin : g_plain
            assign lines[l] = |hit[l];
        end
    end
endmodule

// File: rtl/tir_msg_arb.sv
module tir_msg_arb #(
    parameter int NUM_CH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CH-1:0]    fire,
    input  logic [NUM_CH-1:0]    keep,
    input  logic [NUM_CH*64-1:0] route,
    input  logic                 ready,
    output logic                 valid,
    output logic [31:0]          addr,
    output logic [31:0]          data
);
    typedef struct packed {
        logic [NUM_CH-1:0] pend;
        logic              valid;
        logic [31:0]       addr;
        logic [31:0]       data;
    } arb_t;

    arb_t st_q, st_d;
    logic [NUM_CH-1:0] gmask;
    logic [63:0]       sel;
    logic              can_issue;

    always_comb begin
        st_d      = st_q;
        can_issue = !st_q.valid || ready;
        gmask     = st_q.pend & (~st_q.pend + NUM_CH'(1));
        sel       = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (gmask[c]) sel = route[c*64 +: 64];
        end
        if (!can_issue) gmask = '0;
        if (can_issue) begin
            st_d.valid = |gmask;
            if (|gmask) begin
                st_d.addr = sel[63:32];
                st_d.data = sel[31:0];
            end
        end
        st_d.pend = ((st_q.pend & ~gmask) | fire) & keep;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid = st_q.valid;
    assign addr  = st_q.addr;
    assign data  = st_q.data;
endmodule

// File: rtl/timer_irq_router.sv
module timer_irq_router #(
    parameter int NUM_CH    = 8,
    parameter int NUM_LINES = 24,
    localparam int ROUTE_W  = $clog2(NUM_LINES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      glb_en,
    input  logic                      legacy_mode,
    input  logic [NUM_CH-1:0]         ch_fire,
    input  logic [NUM_CH-1:0]         ch_enable,
    input  logic [NUM_CH-1:0]         ch_level,
    input  logic [NUM_CH-1:0]         ch_msg_en,
    input  logic [NUM_CH*ROUTE_W-1:0] ch_route,
    input  logic [NUM_CH*64-1:0]      ch_msg_route,
    input  logic                      sts_wr,
    input  logic [NUM_CH-1:0]         sts_wdata,
    output logic [NUM_CH-1:0]         sts,
    input  logic                      tmr_legacy_in,
    input  logic                      rtc_legacy_in,
    output logic [NUM_LINES-1:0]      irq_line,
    output logic                      tmr_legacy_en,
    output logic                      msg_valid,
    input  logic                      msg_ready,
    output logic [31:0]               msg_addr,
    output logic [31:0]               msg_data
);
    typedef struct packed {
        logic [NUM_CH-1:0]    status;
        logic [NUM_LINES-1:0] lines;
        logic                 tmr_en;
    } core_t;

    core_t st_q, st_d;

    logic [NUM_CH-1:0]         live, take, lvl_fire, edg_fire, msg_fire, clr;
    logic [NUM_CH-1:0]         active;
    logic [NUM_CH*ROUTE_W-1:0] route_eff;
    logic [NUM_LINES-1:0]      lines_nx;

    tir_route_sel #(.NUM_CH(NUM_CH), .ROUTE_W(ROUTE_W)) u_route (
        .legacy_mode (legacy_mode),
        .route_cfg   (ch_route),
        .route_eff   (route_eff)
    );

    tir_line_map #(.NUM_CH(NUM_CH), .NUM_LINES(NUM_LINES), .ROUTE_W(ROUTE_W)) u_map (
        .active      (active),
        .route_eff   (route_eff),
        .legacy_mode (legacy_mode),
        .tmr_in      (tmr_legacy_in),
        .rtc_in      (rtc_legacy_in),
        .lines       (lines_nx)
    );

    tir_msg_arb #(.NUM_CH(NUM_CH)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (msg_fire),
        .keep  (live & ch_msg_en),
        .route (ch_msg_route),
        .ready (msg_ready),
        .valid (msg_valid),
        .addr  (msg_addr),
        .data  (msg_data)
    );

    always_comb begin
        live     = ch_enable & {NUM_CH{glb_en}};
        take     = ch_fire & live;
        lvl_fire = take & ch_level & ~ch_msg_en;
        edg_fire = take & ~ch_level & ~ch_msg_en;
        msg_fire = take & ch_msg_en;
        clr      = sts_wr ? (sts_wdata & st_q.status) : '0;

        st_d        = st_q;
        st_d.status = ((st_q.status & ~clr & ~edg_fire) | lvl_fire) & live & ~ch_msg_en;
        active      = st_d.status | edg_fire;
        st_d.lines  = lines_nx;
        st_d.tmr_en = !legacy_mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.tmr_en <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sts           = st_q.status;
    assign irq_line      = st_q.lines;
    assign tmr_legacy_en = st_q.tmr_en;
endmodule

// File: rtl/timer_irq_router_chk.sv
module timer_irq_router_chk #(
    parameter int NUM_CH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              glb_en,
    input logic              legacy_mode,
    input logic [NUM_CH-1:0] ch_fire,
    input logic [NUM_CH-1:0] ch_msg_en,
    input logic              sts_wr,
    input logic [NUM_CH-1:0] sts_wdata,
    input logic [NUM_CH-1:0] sts,
    input logic              tmr_legacy_en,
    input logic              msg_valid,
    input logic              msg_ready,
    input logic [31:0]       msg_addr,
    input logic [31:0]       msg_data
);
    AST_GLB_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |=> (sts == '0)); // R5
    AST_W1C_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && ch_fire == '0) |=> ((sts & $past(sts_wdata)) == '0)); // R4
    AST_LEGACY_TMR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_mode |=> !tmr_legacy_en); // R7
    AST_LEGACY_TMR_ON: assert property (@(posedge clk) disable iff (!rst_n)
        !legacy_mode |=> tmr_legacy_en); // R7
    AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data))); // R8
    AST_MSG_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        ch_msg_en != '0 |=> ((sts & $past(ch_msg_en)) == '0)); // R10
endmodule

bind timer_irq_router timer_irq_router_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .glb_en        (glb_en),
    .legacy_mode   (legacy_mode),
    .ch_fire       (ch_fire),
    .ch_msg_en     (ch_msg_en),
    .sts_wr        (sts_wr),
    .sts_wdata     (sts_wdata),
    .sts           (sts),
    .tmr_legacy_en (tmr_legacy_en),
    .msg_valid     (msg_valid),
    .msg_ready     (msg_ready),
    .msg_addr      (msg_addr),
    .msg_data      (msg_data)
);

// File: tb/timer_irq_router_tb.sv
module timer_irq_router_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int NLN = 16;
    localparam int RW  = 4;

    logic clk = 0, rst_n = 0;
    logic glb_en = 0, legacy_mode = 0;
    logic [NCH-1:0] ch_fire = 0, ch_enable = 0, ch_level = 0, ch_msg_en = 0;
    logic [NCH*RW-1:0] ch_route = 0;
    logic [NCH*64-1:0] ch_msg_route;
    logic sts_wr = 0;
    logic [NCH-1:0] sts_wdata = 0;
    logic [NCH-1:0] sts;
    logic tmr_legacy_in = 0, rtc_legacy_in = 0;
    logic [NLN-1:0] irq_line;
    logic tmr_legacy_en, msg_valid, msg_ready = 1;
    logic [31:0] msg_addr, msg_data;

    int total = 0, bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    timer_irq_router #(.NUM_CH(NCH), .NUM_LINES(NLN)) u_dut (.*);

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic fire(logic [NCH-1:0] m);
        ch_fire = m;
        tick();
        ch_fire = 0;
    endtask

    task automatic clear_all();
        sts_wr = 1; sts_wdata = '1;
        tick();
        sts_wr = 0; sts_wdata = 0;
    endtask

    initial begin
        for (int c = 0; c < NCH; c++)
            ch_msg_route[c*64 +: 64] = {32'hA000_0000 + 32'(c), 32'hD000_0000 + 32'(c)};
        repeat (2) @(negedge clk);
        // R1 reset state
        chk("R1 sts", 64'(sts), 0);
        chk("R1 lines", 64'(irq_line), 0);
        chk("R1 valid", 64'(msg_valid), 0);
        chk("R1 tmr_en", 64'(tmr_legacy_en), 1);
        rst_n = 1;
        glb_en = 1; ch_enable = '1;
        tick();

        // R2 / R3 sweep over channel, line and type
        for (int c = 0; c < NCH; c++) begin
            for (int r = 0; r < NLN; r++) begin
                for (int lv = 0; lv < 2; lv++) begin
                    ch_route[c*RW +: RW] = RW'(r);
                    ch_level[c] = lv[0];
                    fire(NCH'(1) << c);
                    chk(lv ? "R2 line" : "R3 line", 64'(irq_line), 64'(1) << r);
                    chk(lv ? "R2 sts" : "R3 sts", 64'(sts), lv ? (64'(1) << c) : 0);
                    tick();
                    chk(lv ? "R2 hold" : "R3 one cycle", 64'(irq_line), lv ? (64'(1) << r) : 0);
                    clear_all();
                    chk("R4 clear all", 64'(irq_line) | (64'(sts) << 32), 0);
                end
            end
            ch_route[c*RW +: RW] = 0;
        end

        // R4 selective clear and fire priority
        ch_level = '1;
        ch_route = {4'd7, 4'd5, 4'd3, 4'd1};
        fire(4'b0101);
        sts_wr = 1; sts_wdata = 4'b0011;
        tick();
        sts_wr = 0;
        chk("R4 partial", 64'(sts), 4'b0100);
        chk("R4 lines", 64'(irq_line), 64'(1) << 5);
        sts_wr = 1; sts_wdata = 4'b0100; ch_fire = 4'b0100;
        tick();
        sts_wr = 0; ch_fire = 0;
        chk("R4 fire wins", 64'(sts), 4'b0100);
        clear_all();

        // R5 disable paths
        fire(4'b1000);
        ch_enable[3] = 0;
        tick();
        chk("R5 ch disable", 64'(sts), 0);
        chk("R5 line", 64'(irq_line), 0);
        fire(4'b1000);
        chk("R5 ignored", 64'(irq_line) | (64'(sts) << 32), 0);
        ch_enable[3] = 1;
        fire(4'b0010);
        glb_en = 0;
        tick();
        chk("R5 glb off", 64'(sts), 0);
        fire(4'b0010);
        chk("R5 glb ignored", 64'(irq_line) | (64'(sts) << 32), 0);
        glb_en = 1;

        // R6 legacy routing
        ch_route = {4'd5, 4'd5, 4'd5, 4'd5};
        legacy_mode = 1;
        ch_level = 4'b0101;
        fire(4'b0111);
        chk("R6 lines", 64'(irq_line), (64'(1) << 0) | (64'(1) << 8) | (64'(1) << 5));
        tick();
        chk("R6 ch1 pulse", 64'(irq_line), (64'(1) << 0) | (64'(1) << 5));
        clear_all();

        // R7 legacy inputs
        legacy_mode = 0;
        tmr_legacy_in = 1; rtc_legacy_in = 1;
        tick();
        chk("R7 pass", 64'(irq_line), (64'(1) << 0) | (64'(1) << 8));
        chk("R7 en", 64'(tmr_legacy_en), 1);
        legacy_mode = 1;
        tick();
        chk("R7 blocked", 64'(irq_line), 0);
        chk("R7 en off", 64'(tmr_legacy_en), 0);
        rtc_legacy_in = 0;
        tick();
        rtc_legacy_in = 1;
        legacy_mode = 0;
        tick();
        chk("R7 restore", 64'(irq_line), (64'(1) << 0) | (64'(1) << 8));
        chk("R7 en back", 64'(tmr_legacy_en), 1);
        tmr_legacy_in = 0; rtc_legacy_in = 0;
        tick();

        // R10 message enable drops status
        ch_level = '1;
        fire(4'b0100);
        chk("R10 pre", 64'(sts), 4'b0100);
        ch_msg_en[2] = 1;
        tick();
        chk("R10 sts", 64'(sts), 0);
        chk("R10 line", 64'(irq_line), 0);
        ch_msg_en = 0;

        // R8 message write with back-pressure
        ch_msg_en = 4'b0010;
        msg_ready = 0;
        fire(4'b0010);
        chk("R8 no line", 64'(irq_line) | (64'(sts) << 32), 0);
        chk("R8 not yet", 64'(msg_valid), 0);
        tick();
        chk("R8 valid", 64'(msg_valid), 1);
        chk("R8 addr", 64'(msg_addr), 32'hA000_0001);
        chk("R8 data", 64'(msg_data), 32'hD000_0001);
        tick(); tick();
        chk("R8 held", {31'(0), msg_valid, msg_addr}, {31'(0), 1'b1, 32'hA000_0001});
        msg_ready = 1;
        tick();
        chk("R8 done", 64'(msg_valid), 0);

        // R9 ordering of simultaneous message fires
        ch_msg_en = '1;
        fire(4'b1111);
        for (int c = 0; c < NCH; c++) begin
            tick();
            chk("R9 valid", 64'(msg_valid), 1);
            chk("R9 order", {msg_addr, msg_data},
                {32'hA000_0000 + 32'(c), 32'hD000_0000 + 32'(c)});
        end
        tick();
        chk("R9 once", 64'(msg_valid), 0);
        chk("R9 no line", 64'(irq_line), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule